// File: doc/BRIEF.md
# Surface code decoder mesh cell

This block is a single cell of a rectangular decoder mesh, with one copy placed at every data or ancilla qubit position. Every cell talks to four neighbours (up, left, right, down) over four one-bit signal kinds: grow, pair request, pair grant and pair. A cell whose syndrome measurement was hot floods grow signals outward, one cell per clock. Where two wavefronts collide, the cell there becomes an intermediate. It asks both hot origins to pair, collects their grants and sends pair signals back along both paths. Every cell that a pair signal crosses is marked as part of the correction chain.

When a pair signal lands on a hot cell, that cell drops its hot state and raises a global reset request. The surrounding mesh ORs these requests and returns the result to every cell. The cell then ignores grow, request and grant traffic for a fixed number of cycles while the network drains. Pair signals still in flight are never blocked, so they can finish. Mesh wiring, boundary cells and decode sequencing sit outside this block.

Top module: `sc_mesh_cell`

## Requirements
- R1: After reset, and after a decode-start strobe that loads a cold syndrome, every output is 0.
- R2: A decode-start strobe loads `syndrome_in` into the hot state. While the cell is hot, `grow_out` is 4'b1111 from the cycle after the strobe, and the cell neither forwards nor originates requests. Direction bit d of every 4-bit port refers to the neighbour on side d: 0 = up, 1 = left, 2 = right, 3 = down.
- R3: A cold cell forwards each grow arriving on side d out of the opposite side (3-d) one clock later.
- R4: When two or more grows arrive at a cold cell in the same cycle, the cell becomes an intermediate. One clock later it drives `req_out` on the two lowest-numbered arrival sides (priority up, left, right, down). A hot cell never becomes an intermediate.
- R5: A cold cell forwards a request arriving on side d out of side 3-d one clock later.
- R6: A hot cell does not forward requests. It answers them one clock later with a grant on exactly one side: the lowest-numbered side that carried a request.
- R7: A cold cell that is not an intermediate forwards a grant arriving on side d out of side 3-d one clock later.
- R8: An intermediate consumes grants that arrive on its two request sides, and these grants may come in different cycles. One clock after the second of them arrives, it drives `pair_out` on both request sides and sets `error_out`.
- R9: A cold cell forwards a pair arriving on side d out of side 3-d one clock later. Any incoming pair sets `error_out`.
- R10: A hot cell that receives a pair does not forward it. One clock later it pulses `glb_rst_req` high for one cycle and leaves the hot state, so `grow_out` returns to 0.
- R11: Grow, request and grant inputs are ignored at the clock edge where `glb_rst_in` is sampled high and at the following BLOCK_CYC-1 edges (5 edges in total by default). They take effect again at the next edge.
- R12: Pair inputs are never blocked. They are forwarded even inside the R11 window.
- R13: `error_out` stays set through global resets and clears only on a decode-start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| decode_start | input | 1 | Strobe: load syndrome, clear error and intermediate state |
| syndrome_in | input | 1 | Syndrome bit sampled on decode_start |
| glb_rst_in | input | 1 | Mesh-wide OR of all pairing reset requests |
| grow_in | input | 4 | Grow from each neighbour side |
| req_in | input | 4 | Pair request from each neighbour side |
| gnt_in | input | 4 | Pair grant from each neighbour side |
| pair_in | input | 4 | Pair signal from each neighbour side |
| grow_out | output | 4 | Grow toward each neighbour side |
| req_out | output | 4 | Pair request toward each neighbour side |
| gnt_out | output | 4 | Pair grant toward each neighbour side |
| pair_out | output | 4 | Pair signal toward each neighbour side |
| glb_rst_req | output | 1 | One-cycle pairing reset request |
| error_out | output | 1 | Sticky correction-chain mark |

## Verification
Every forwarded or answered signal is registered, so it shows at the ports one clock after the edge that samples its cause. The one exception is the hot grow pattern, which follows the hot state directly and is therefore visible right after the decode-start edge. The bench drives a single isolated cell, queues the expected port vector for every driven edge, and compares that vector shortly after the edge. The blocking window is probed at each of its five edges and at the first edge after it. The multi-cycle grant collection is probed both with the first grant alone and with the second.

// File: rtl/sc_cell_pkg.sv
package sc_cell_pkg;
   localparam int NUM_DIR = 4;

   typedef logic [NUM_DIR-1:0] dirv_t;

   // side d of arrival maps to side (NUM_DIR-1-d) of departure
   function automatic dirv_t turn_over(dirv_t v);
      dirv_t r;
      for (int d = 0; d < NUM_DIR; d++) r[NUM_DIR-1-d] = v[d];
      return r;
   endfunction
endpackage

// File: rtl/sc_block_timer.sv
module sc_block_timer #(
   parameter int HOLD = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic hold
);
   localparam int STAGES = HOLD - 1;

   generate
      if (HOLD < 2) begin : g_bad
         $error("sc_block_timer: HOLD must be at least 2");
      end
      if (STAGES == 1) begin : g_single
         logic st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= 1'b0;
            else        st_q <= trig;
         end
         assign hold = trig | st_q;
      end else begin : g_chain
         logic [STAGES-1:0] st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= {st_q[STAGES-2:0], trig};
         end
         assign hold = trig | (|st_q);
      end
   endgenerate
endmodule

// File: rtl/sc_prio_pick.sv
module sc_prio_pick #(
   parameter int N    = 4,
   parameter int KEEP = 1
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] pick
);
   logic [N-1:0] rem [KEEP+1];

   generate
      if (KEEP < 1 || KEEP > N) begin : g_bad
         $error("sc_prio_pick: KEEP out of range");
      end
   endgenerate

   assign rem[0] = req;

   for (genvar k = 0; k < KEEP; k++) begin : g_stage
      logic [N-1:0] sel;
      always_comb begin
         sel = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (rem[k][i]) begin
               sel    = '0;
               sel[i] = 1'b1;
            end
         end
      end
      assign rem[k+1] = rem[k] & ~sel;
   end

   assign pick = req & ~rem[KEEP];
endmodule

// File: rtl/sc_mesh_cell.sv
module sc_mesh_cell
   import sc_cell_pkg::*;
#(
   parameter int BLOCK_CYC = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       decode_start,
   input  logic       syndrome_in,
   input  logic       glb_rst_in,
   input  logic [3:0] grow_in,
   input  logic [3:0] req_in,
   input  logic [3:0] gnt_in,
   input  logic [3:0] pair_in,
   output logic [3:0] grow_out,
   output logic [3:0] req_out,
   output logic [3:0] gnt_out,
   output logic [3:0] pair_out,
   output logic       glb_rst_req,
   output logic       error_out
);
   generate
      if (NUM_DIR != 4) begin : g_bad
         $error("sc_mesh_cell: four neighbour sides expected");
      end
   endgenerate

   logic  blk;
   dirv_t g_m, r_m, a_m;
   dirv_t gnt_pick, meet_two;
   logic  meet;

   logic  hot_q, inter_q, rst_q, err_q;
   dirv_t side_q, got_q, gfwd_q, req_q, gnt_q, pair_q;
   dirv_t got_nx, cons;
   logic  done;

   sc_block_timer #(.HOLD(BLOCK_CYC)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (glb_rst_in),
      .hold (blk)
   );

   assign g_m = blk ? '0 : grow_in;
   assign r_m = blk ? '0 : req_in;
   assign a_m = blk ? '0 : gnt_in;

   sc_prio_pick #(.N(NUM_DIR), .KEEP(1)) u_gnt_pick (
      .req (r_m),
      .pick(gnt_pick)
   );

   sc_prio_pick #(.N(NUM_DIR), .KEEP(2)) u_meet_pick (
      .req (g_m),
      .pick(meet_two)
   );

   assign meet   = ($countones(g_m) >= 2) && !hot_q;
   assign cons   = inter_q ? side_q : '0;
   assign got_nx = got_q | (a_m & cons);
   assign done   = inter_q && ((got_nx & side_q) == side_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hot_q   <= 1'b0;
         inter_q <= 1'b0;
         side_q  <= '0;
         got_q   <= '0;
         gfwd_q  <= '0;
         req_q   <= '0;
         gnt_q   <= '0;
         pair_q  <= '0;
         rst_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         gfwd_q <= hot_q ? '0 : turn_over(g_m);
         req_q  <= hot_q ? '0 : (turn_over(r_m) | ((meet && !inter_q) ? meet_two : '0));
         gnt_q  <= hot_q ? gnt_pick : turn_over(a_m & ~cons);
         pair_q <= hot_q ? '0 : (turn_over(pair_in) | (done ? side_q : '0));
         rst_q  <= hot_q && (|pair_in);

         if (decode_start)                 hot_q <= syndrome_in;
         else if (hot_q && (|pair_in))     hot_q <= 1'b0;

         if (decode_start || blk || done) begin
            inter_q <= 1'b0;
            got_q   <= '0;
         end else if (!inter_q && meet) begin
            inter_q <= 1'b1;
            side_q  <= meet_two;
            got_q   <= '0;
         end else begin
            got_q   <= got_nx;
         end

         if (decode_start)                 err_q <= 1'b0;
         else if ((|pair_in) || done)      err_q <= 1'b1;
      end
   end

   assign grow_out    = {NUM_DIR{hot_q}} | gfwd_q;
   assign req_out     = req_q;
   assign gnt_out     = gnt_q;
   assign pair_out    = pair_q;
   assign glb_rst_req = rst_q;
   assign error_out   = err_q;

   // R6: a hot cell grants at most one side
   a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      hot_q && !decode_start |=> $onehot0(gnt_out));

   // R10: pair landing on a hot cell raises the reset request and cools it
   a_r10_pair_ends_hot: assert property (@(posedge clk) disable iff (!rst_n)
      hot_q && (|pair_in) && !decode_start |=> glb_rst_req && !hot_q);

   // R11: no request leaves the cell right after a global reset
   a_r11_block_req: assert property (@(posedge clk) disable iff (!rst_n)
      glb_rst_in |=> (req_out == '0));

   // R12: pairs pass a cold cell even while blocked
   a_r12_pair_passes: assert property (@(posedge clk) disable iff (!rst_n)
      !hot_q && pair_in[0] |=> pair_out[3]);

   // R9: any incoming pair marks the chain
   a_r9_pair_marks: assert property (@(posedge clk) disable iff (!rst_n)
      (|pair_in) && !decode_start |=> error_out);

   // R13: the mark holds until a decode-start strobe
   a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      error_out && !decode_start |=> error_out);
endmodule

// File: tb/sc_mesh_cell_tb_top.sv
module sc_mesh_cell_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       decode_start = 1'b0, syndrome_in = 1'b0, glb_rst_in = 1'b0;
   logic [3:0] grow_in = '0, req_in = '0, gnt_in = '0, pair_in = '0;
   logic [3:0] grow_out, req_out, gnt_out, pair_out;
   logic       glb_rst_req, error_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done_drv = 1'b0;

   typedef struct {
      logic [17:0] exp;
      string       tag;
   } item_t;

   item_t q[$];

   always #4 clk = ~clk;   // 125 MHz

   sc_mesh_cell dut_i (
      .clk(clk), .rst_n(rst_n), .decode_start(decode_start),
      .syndrome_in(syndrome_in), .glb_rst_in(glb_rst_in),
      .grow_in(grow_in), .req_in(req_in), .gnt_in(gnt_in), .pair_in(pair_in),
      .grow_out(grow_out), .req_out(req_out), .gnt_out(gnt_out),
      .pair_out(pair_out), .glb_rst_req(glb_rst_req), .error_out(error_out)
   );

   // expected vector order: grow, req, gnt, pair, rst_req, error
   function automatic logic [17:0] pk(logic [3:0] g, logic [3:0] r, logic [3:0] a,
                                      logic [3:0] p, logic rs, logic e);
      return {g, r, a, p, rs, e};
   endfunction

   task automatic step(input logic ds, input logic syn, input logic gr,
                       input logic [3:0] g, input logic [3:0] r,
                       input logic [3:0] a, input logic [3:0] p,
                       input logic [17:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      decode_start = ds; syndrome_in = syn; glb_rst_in = gr;
      grow_in = g; req_in = r; gnt_in = a; pair_in = p;
      it.exp = exp;
      it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: compare 2 ns after every rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            item_t it;
            logic [17:0] act;
            it  = q.pop_front();
            act = {grow_out, req_out, gnt_out, pair_out, glb_rst_req, error_out};
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      n_cmp++;
      if ({grow_out, req_out, gnt_out, pair_out, glb_rst_req, error_out} !== '0) begin
         n_bad++;
         $display("FAIL R1: actual %b expected 0",
                  {grow_out, req_out, gnt_out, pair_out, glb_rst_req, error_out});
      end
      rst_n = 1'b1;
      //    ds syn gr grow     req      gnt      pair
      step(1, 0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, pk(0, 0, 0, 0, 0, 0), "R1");
      step(0, 0, 0, 4'b0001, 4'b0000, 4'b0000, 4'b0000, pk(4'b1000, 0, 0, 0, 0, 0), "R3");
      step(0, 0, 0, 4'b0100, 4'b0000, 4'b0000, 4'b0000, pk(4'b0010, 0, 0, 0, 0, 0), "R3");
      step(0, 0, 0, 4'b0000, 4'b0010, 4'b0000, 4'b0000, pk(0, 4'b0100, 0, 0, 0, 0), "R5");
      step(0, 0, 0, 4'b0000, 4'b0000, 4'b1000, 4'b0000, pk(0, 0, 4'b0001, 0, 0, 0), "R7");
      step(0, 0, 0, 4'b0111, 4'b0000, 4'b0000, 4'b0000, pk(4'b1110, 4'b0011, 0, 0, 0, 0), "R4");
      step(0, 0, 0, 4'b0000, 4'b0000, 4'b0001, 4'b0000, pk(0, 0, 0, 0, 0, 0), "R8");
      step(0, 0, 0, 4'b0000, 4'b0000, 4'b0010, 4'b0000, pk(0, 0, 0, 4'b0011, 0, 1), "R8");
      step(0, 0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0001, pk(0, 0, 0, 4'b1000, 0, 1), "R9");
      step(0, 0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, pk(0, 0, 0, 0, 0, 1), "R13");
      step(1, 1, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, pk(4'b1111, 0, 0, 0, 0, 0), "R2");
      step(0, 0, 0, 4'b0000, 4'b1100, 4'b0000, 4'b0000, pk(4'b1111, 0, 4'b0100, 0, 0, 0), "R6");
      step(0, 0, 0, 4'b0000, 4'b1111, 4'b0000, 4'b0000, pk(4'b1111, 0, 4'b0001, 0, 0, 0), "R6");
      step(0, 0, 0, 4'b0011, 4'b0000, 4'b0000, 4'b0000, pk(4'b1111, 0, 0, 0, 0, 0), "R2");
      step(0, 0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0100, pk(0, 0, 0, 0, 1, 1), "R10");
      step(0, 0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, pk(0, 0, 0, 0, 0, 1), "R10");
      step(0, 0, 1, 4'b0001, 4'b0000, 4'b0000, 4'b0000, pk(0, 0, 0, 0, 0, 1), "R11");
      step(0, 0, 0, 4'b0001, 4'b0000, 4'b0000, 4'b0000, pk(0, 0, 0, 0, 0, 1), "R11");
      step(0, 0, 0, 4'b0001, 4'b0000, 4'b0001, 4'b0010, pk(0, 0, 0, 4'b0100, 0, 1), "R12");
      step(0, 0, 0, 4'b0001, 4'b0001, 4'b0000, 4'b0000, pk(0, 0, 0, 0, 0, 1), "R11");
      step(0, 0, 0, 4'b0001, 4'b0000, 4'b0000, 4'b0000, pk(0, 0, 0, 0, 0, 1), "R11");
      step(0, 0, 0, 4'b0001, 4'b0000, 4'b0000, 4'b0000, pk(4'b1000, 0, 0, 0, 0, 1), "R11");
      step(1, 0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, pk(0, 0, 0, 0, 0, 0), "R13");
      step(0, 0, 0, 4'b1110, 4'b0000, 4'b0000, 4'b0000, pk(4'b0111, 4'b0110, 0, 0, 0, 0), "R4");
      step(0, 0, 0, 4'b0000, 4'b0000, 4'b0110, 4'b0000, pk(0, 0, 0, 4'b0110, 0, 1), "R8");
      step(0, 0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, pk(0, 0, 0, 0, 0, 1), "R13");
      repeat (3) @(negedge clk);
      done_drv = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done_drv && cyc < 2000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done_drv) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule